// File: doc/BRIEF.md
# Signed Decimal Adder-Subtractor

This block adds or subtracts two signed decimal numbers held in packed BCD. Each operand is a row of BCD magnitude digits topped by one 4-bit sign digit. A positive value carries a sign digit of 0000, and a negative value carries 1001. Negative values are stored in 10's-complement form. The sign digit is treated as one more decimal digit of the number.

A control input picks the operation. To add, the digits of the two operands are summed directly. To subtract, the subtrahend is first turned into its 10's complement and then added. The complement works by replacing every digit d with 9 − d and feeding a one into the least significant digit. Each digit slice adds in binary, and any sum above nine is corrected by adding six. The slice then passes a decimal carry to the next digit. The carry out of the sign digit is not part of the result; it is reported on its own output. An overflow flag marks a result that cannot be represented.

The result, the end carry and the overflow flag are captured on the rising clock edge when the input is marked valid. A done pulse follows one cycle later.

Top module: `dec_signed_addsub`

## Requirements
- R1: While reset is asserted, and after its release until the first valid operation, `sum_o` is zero, `cout_o` is 0, `ovf_o` is 0 and `done_o` is 0.
- R2: Operands and the result share one packed layout. Digit k of the magnitude occupies bits [4k+3:4k], with digit 0 least significant. The sign digit occupies the top nibble, bits [4*NDIG+3:4*NDIG]. A sign digit of 0000 means positive and 1001 means negative, and a negative value V is held as 10^(NDIG+1) + V.
- R3: With `sub_i` = 0, `sum_o` holds (A + B) mod 10^(NDIG+1). Here A and B are the packed operands, each read as a decimal integer of NDIG+1 digits with the sign digit included.
- R4: With `sub_i` = 1, `sum_o` holds (A + (10^(NDIG+1) − 1 − B) + 1) mod 10^(NDIG+1). This is A plus the 10's complement of B, formed as the digit-wise 9's complement plus one in the least significant digit.
- R5: For operands whose digits are all valid BCD, every digit of the result is in the range 0 to 9. A digit slice whose binary sum exceeds nine is corrected by adding six and passes a carry of one to the next digit.
- R6: `cout_o` is the carry out of the sign digit, which is 1 exactly when the sum before the modulo in R3/R4 reaches 10^(NDIG+1). That carry never appears in `sum_o`.
- R7: `ovf_o` is 1 exactly when the signed result lies outside −10^NDIG to 10^NDIG − 1. Equivalently, it is 1 when A's sign digit equals the effective sign digit of the second addend and the result's sign digit differs from it. The effective sign digit is B's sign digit when adding, and 9 minus it when subtracting.
- R8: The outputs are loaded on a rising edge where `in_valid_i` is 1. `done_o` is 1 in the cycle after such an edge and 0 in the cycle after an edge where `in_valid_i` is 0.
- R9: When `in_valid_i` is 0, a change on `a_i`, `b_i` or `sub_i` has no effect: `sum_o`, `cout_o` and `ovf_o` keep their values.
- R10: A negative result stays in 10's-complement form with sign digit 1001. For example, 3 − 5 yields sign 1001 and magnitude digits 9998.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Operands valid; capture result on this edge |
| sub_i | input | 1 | 0 = add, 1 = subtract b from a |
| a_i | input | 4*(NDIG+1) | First operand, packed signed BCD |
| b_i | input | 4*(NDIG+1) | Second operand, packed signed BCD |
| sum_o | output | 4*(NDIG+1) | Registered packed signed-BCD result |
| cout_o | output | 1 | Registered end carry out of the sign digit |
| ovf_o | output | 1 | Registered overflow flag |
| done_o | output | 1 | One-cycle pulse after a captured operation |

## Verification
The assertions on digit range and on a valid sign digit assume well-formed operands. Every magnitude digit must be in 0–9 and every sign digit must be 0000 or 1001. Behaviour on unused codes 1010–1111 is not defined. The bench builds all operands from signed integers in the range −10^NDIG to 10^NDIG − 1 through a conversion routine, so no malformed digit ever reaches the block. It changes operands during idle cycles only with valid low, so that the hold property is exercised.

// File: rtl/dec_signed_addsub.sv
`timescale 1ns/1ps
module dec_signed_addsub #(
  parameter int NDIG = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid_i,
  input  logic                  sub_i,
  input  logic [4*(NDIG+1)-1:0] a_i,
  input  logic [4*(NDIG+1)-1:0] b_i,
  output logic [4*(NDIG+1)-1:0] sum_o,
  output logic                  cout_o,
  output logic                  ovf_o,
  output logic                  done_o
);
  localparam int ND = NDIG + 1;
  localparam int W  = 4 * ND;

  logic [ND:0]  cy;
  logic [W-1:0] sum_c;
  logic [3:0]   sa, sb_eff, sr;
  logic         ovf_c;

  assign cy[0] = sub_i;

  for (genvar i = 0; i < ND; i++) begin : g_dig
    logic [3:0] ad, bd, bx;
    logic [4:0] raw;
    assign ad  = a_i[4*i +: 4];
    assign bd  = b_i[4*i +: 4];
    assign bx  = sub_i ? (4'd9 - bd) : bd;
    assign raw = {1'b0, ad} + {1'b0, bx} + {4'b0, cy[i]};
    assign cy[i+1] = (raw > 5'd9);
    assign sum_c[4*i +: 4] = cy[i+1] ? (raw[3:0] + 4'd6) : raw[3:0];
  end

  assign sa     = a_i[W-1 -: 4];
  assign sb_eff = sub_i ? (4'd9 - b_i[W-1 -: 4]) : b_i[W-1 -: 4];
  assign sr     = sum_c[W-1 -: 4];
  assign ovf_c  = (sa == sb_eff) && (sr != sa);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_o  <= '0;
      cout_o <= 1'b0;
      ovf_o  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= in_valid_i;
      if (in_valid_i) begin
        sum_o  <= sum_c;
        cout_o <= cy[ND];
        ovf_o  <= ovf_c;
      end
    end
  end
endmodule

// File: rtl/dec_signed_addsub_chk.sv
`timescale 1ns/1ps
module dec_signed_addsub_chk #(
  parameter int NDIG = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid_i,
  input logic                  sub_i,
  input logic [4*(NDIG+1)-1:0] a_i,
  input logic [4*(NDIG+1)-1:0] b_i,
  input logic [4*(NDIG+1)-1:0] sum_o,
  input logic                  cout_o,
  input logic                  ovf_o,
  input logic                  done_o
);
  localparam int W = 4 * (NDIG + 1);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> done_o);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> !done_o);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> ($stable(sum_o) && $stable(cout_o) && $stable(ovf_o)));

  p_add_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && !sub_i && b_i == '0) |=> (sum_o == $past(a_i) && !cout_o && !ovf_o));

  p_sign_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !ovf_o) |-> (sum_o[W-1 -: 4] == 4'd0 || sum_o[W-1 -: 4] == 4'd9));

  for (genvar i = 0; i < NDIG + 1; i++) begin : g_bcd
    p_digit_bcd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (sum_o[4*i +: 4] <= 4'd9));
  end
endmodule

bind dec_signed_addsub dec_signed_addsub_chk #(.NDIG(NDIG)) u_chk (.*);

// File: tb/dec_signed_addsub_tb.sv
`timescale 1ns/1ps
module dec_signed_addsub_tb;
  localparam int NDIG = 4;
  localparam int W = 4 * (NDIG + 1);
  localparam int MODV = 100000;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, sub = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [W-1:0] sum;
  logic cout, ovf, done;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dec_signed_addsub #(.NDIG(NDIG)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .sub_i(sub),
    .a_i(a), .b_i(b), .sum_o(sum), .cout_o(cout), .ovf_o(ovf), .done_o(done));

  function automatic logic [W-1:0] to_bcd(input int raw);
    logic [W-1:0] r = '0;
    int v = raw;
    for (int k = 0; k < NDIG + 1; k++) begin
      r[4*k +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  function automatic int to_raw(input int v);
    return (v < 0) ? v + MODV : v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input int av, input int bv, input bit s, input string req);
    int ra = to_raw(av), rb = to_raw(bv);
    int tot = ra + (s ? (MODV - 1 - rb) + 1 : rb);
    int tv = s ? av - bv : av + bv;
    logic [W-1:0] e_sum = to_bcd(tot % MODV);
    bit e_c = (tot >= MODV);
    bit e_o = (tv > 9999) || (tv < -10000);
    @(negedge clk);
    a = to_bcd(ra); b = to_bcd(rb); sub = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(sum == e_sum, {req, " sum"}, 32'(sum), 32'(e_sum));
    chk(cout == e_c, {req, " R6 carry"}, 32'(cout), 32'(e_c));
    chk(ovf == e_o, {req, " R7 overflow"}, 32'(ovf), 32'(e_o));
    chk(done == 1'b1, {req, " R8 done"}, 32'(done), 32'd1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(sum == '0 && !cout && !ovf && !done, "R1 reset", {cout, ovf, done, 9'd0, sum}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sum == '0 && !done, "R1 after release", {done, 11'd0, sum}, 32'd0);
  endtask

  task automatic t_hold;
    logic [W-1:0] s0 = sum;
    logic c0 = cout, o0 = ovf;
    a = to_bcd(9999); b = to_bcd(9999); sub = 1'b0;
    @(negedge clk);
    a = to_bcd(to_raw(-1)); sub = 1'b1;
    @(negedge clk);
    chk(sum == s0 && cout == c0 && ovf == o0, "R9 hold", {cout, ovf, 10'd0, sum}, {c0, o0, 10'd0, s0});
    chk(done == 1'b0, "R8 done idle", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    run_op(1234, 4321, 1'b0, "R3 R2 add plain");
    run_op(999, 1, 1'b0, "R5 decimal carry chain");
    run_op(5678, 4567, 1'b0, "R7 pos overflow");
    run_op(9999, 1, 1'b0, "R7 max plus one");
    run_op(-3, -4, 1'b0, "R3 neg plus neg");
    run_op(-10000, -1, 1'b0, "R7 neg overflow");
    run_op(-2500, 700, 1'b0, "R3 mixed signs");
    run_op(3, 5, 1'b1, "R10 R4 negative result");
    run_op(1234, 0, 1'b1, "R4 R6 minus zero");
    run_op(4000, 1234, 1'b1, "R4 positive diff");
    run_op(0, -10000, 1'b1, "R7 minus most negative");
    run_op(-5, -10000, 1'b1, "R4 neg minus most negative");
    run_op(-9999, 2, 1'b1, "R7 neg minus pos overflow");
    t_hold();
    run_op(-1, -1, 1'b0, "R10 R5 all nines");
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule